// File: doc/BRIEF.md
# Multi-channel DMA interrupt and register front end

This block is the register-facing side of a DMA engine with up to eight channels. It decodes a simple 32-bit memory-mapped register bus. Behind that bus sit three things: a one-bit address-width control, a global interrupt group (status, pending and enable), and one register window per pair of channels. Each channel engine signals the end of a transfer with a one-cycle completion pulse. That pulse sets the channel's status bit. Software clears the bit by writing a one to it. The block raises a single level-sensitive interrupt while any enabled channel has its status bit set.

Channels are grouped in pairs. Within pair p, channel 2p receives and channel 2p+1 transmits. Each pair owns a 64-byte window starting at 0x40·p. The receive registers sit at the bottom of the window and the transmit registers begin 0x18 bytes in. The register contents are handed to the channel engines as plain output ports. Reads return data one cycle after the request.

Top module: `dmairq_regfile`

## Requirements
- R1: After reset, the status, enable and address-mode registers hold zero, `irq` is low, every channel window register holds zero and `bus_rdata` is zero.
- R2: A one-cycle pulse on `ch_done[n]` sets bit n of the status register, which is read at offset 0x080000. Bit n of status, pending and enable always belongs to channel n.
- R3: A write to offset 0x080000 clears exactly those status bits whose write-data bit is 1. Writing 0xFFFFFFFF clears all of them. Without a write or a pulse, the status holds.
- R4: When a completion pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The pending register at offset 0x080004 reads status AND enable. Writes to it have no effect.
- R6: `irq` is high exactly when status AND enable is nonzero.
- R7: The enable register at offset 0x080008 is read/write. Bits at or above NUM_CH read as zero in status, pending and enable.
- R8: Offset 0x34 holds the address-mode bit in bit 0. Writing 0x01 there drives `addr32_mode` high. Writing 0 drives it low. Its other bits read as zero.
- R9: In the window of pair p (base 0x40·p), the receive channel 2p has its descriptor high word at +0x00, its descriptor low word at +0x04, a run bit in bit 0 of +0x14 and a ROW_W-bit line-size field at +0x30. The transmit channel 2p+1 has its descriptor high word at +0x18 and its low word at +0x1C. Each of these registers reads back and drives its channel's output slice.
- R10: `bus_rdata` shows the addressed register value in the cycle after `bus_rd`. Unmapped offsets read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 20 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| ch_done | input | NUM_CH | Per-channel completion pulse |
| ch_desc_hi | output | NUM_CH*32 | Descriptor high word, channel n at slice n |
| ch_desc_lo | output | NUM_CH*32 | Descriptor low word, channel n at slice n |
| rx_run | output | NUM_CH/2 | Run bit of each receive channel, one per pair |
| rx_row_bytes | output | NUM_CH/2*ROW_W | Line size of each receive channel |
| addr32_mode | output | 1 | Address-mode bit |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act on the same status flip-flop in one cycle: a completion pulse from a channel engine and a software write-one-to-clear. The bench drives a clear write and a pulse in the same clock edge. It does this once on the same bit, and once on different bits, so that one bit is cleared while another is set. It then judges the outcome from a status read and from the level of `irq`. The same bit must stay set. In the mixed case, only the newly pulsed bit may remain.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int unsigned BUS_AW = 20;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned MAX_CH = 8;

  // global register offsets
  localparam logic [BUS_AW-1:0] OFS_STATUS = 20'h8_0000;
  localparam logic [BUS_AW-1:0] OFS_PEND   = 20'h8_0004;
  localparam logic [BUS_AW-1:0] OFS_ENABLE = 20'h8_0008;
  localparam logic [BUS_AW-1:0] OFS_AMODE  = 20'h0_0034;

  // offsets inside a pair window (window stride is 1 << WIN_SHIFT)
  localparam int unsigned WIN_SHIFT = 6;
  localparam logic [WIN_SHIFT-1:0] WOFS_RX_DHI = 6'h00;
  localparam logic [WIN_SHIFT-1:0] WOFS_RX_DLO = 6'h04;
  localparam logic [WIN_SHIFT-1:0] WOFS_RX_RUN = 6'h14;
  localparam logic [WIN_SHIFT-1:0] WOFS_TX_DHI = 6'h18;
  localparam logic [WIN_SHIFT-1:0] WOFS_TX_DLO = 6'h1C;
  localparam logic [WIN_SHIFT-1:0] WOFS_RX_ROW = 6'h30;
endpackage

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] en_wdata,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] sts_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] sts_q, sts_d;
  logic [NUM_CH-1:0] en_q, en_d;

  // the completion pulse is OR-ed in after the clear, so it wins a collision
  always_comb begin
    sts_d = sts_q;
    if (clr_we) sts_d = sts_d & ~clr_mask;
    sts_d = sts_d | done_i;
    en_d  = en_we ? en_wdata : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts_o  = sts_q;
  assign en_o   = en_q;
  assign pend_o = sts_q & en_q;
  assign irq_o  = |pend_o;
endmodule

// File: rtl/dmairq_pair.sv
module dmairq_pair
  import dmairq_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned ROW_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 wr_en,
  input  logic [WIN_SHIFT-1:0] off,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [DW-1:0]        rx_dhi,
  output logic [DW-1:0]        rx_dlo,
  output logic [DW-1:0]        tx_dhi,
  output logic [DW-1:0]        tx_dlo,
  output logic                 rx_run,
  output logic [ROW_W-1:0]     rx_row
);
  logic [DW-1:0]    rx_dhi_q, rx_dhi_d, rx_dlo_q, rx_dlo_d;
  logic [DW-1:0]    tx_dhi_q, tx_dhi_d, tx_dlo_q, tx_dlo_d;
  logic             run_q, run_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             we;

  assign we = wr_en & sel;

  always_comb begin
    rx_dhi_d = (we && off == WOFS_RX_DHI) ? wdata : rx_dhi_q;
    rx_dlo_d = (we && off == WOFS_RX_DLO) ? wdata : rx_dlo_q;
    tx_dhi_d = (we && off == WOFS_TX_DHI) ? wdata : tx_dhi_q;
    tx_dlo_d = (we && off == WOFS_TX_DLO) ? wdata : tx_dlo_q;
    run_d    = (we && off == WOFS_RX_RUN) ? wdata[0] : run_q;
    row_d    = (we && off == WOFS_RX_ROW) ? wdata[ROW_W-1:0] : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_dhi_q <= '0;
      rx_dlo_q <= '0;
      tx_dhi_q <= '0;
      tx_dlo_q <= '0;
      run_q    <= 1'b0;
      row_q    <= '0;
    end else begin
      rx_dhi_q <= rx_dhi_d;
      rx_dlo_q <= rx_dlo_d;
      tx_dhi_q <= tx_dhi_d;
      tx_dlo_q <= tx_dlo_d;
      run_q    <= run_d;
      row_q    <= row_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel) begin
      case (off)
        WOFS_RX_DHI: rdata = rx_dhi_q;
        WOFS_RX_DLO: rdata = rx_dlo_q;
        WOFS_TX_DHI: rdata = tx_dhi_q;
        WOFS_TX_DLO: rdata = tx_dlo_q;
        WOFS_RX_RUN: rdata = DW'(run_q);
        WOFS_RX_ROW: rdata = DW'(row_q);
        default:     rdata = '0;
      endcase
    end
  end

  assign rx_dhi = rx_dhi_q;
  assign rx_dlo = rx_dlo_q;
  assign tx_dhi = tx_dhi_q;
  assign tx_dlo = tx_dlo_q;
  assign rx_run = run_q;
  assign rx_row = row_q;
endmodule

// File: rtl/dmairq_regfile.sv
module dmairq_regfile
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6,
  parameter int unsigned ROW_W  = 16,
  localparam int unsigned NUM_PAIRS = NUM_CH / 2,
  localparam int unsigned PAIR_AW   = BUS_AW - WIN_SHIFT
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [BUS_DW-1:0]         bus_wdata,
  output logic [BUS_DW-1:0]         bus_rdata,
  input  logic [NUM_CH-1:0]         ch_done,
  output logic [NUM_CH*BUS_DW-1:0]  ch_desc_hi,
  output logic [NUM_CH*BUS_DW-1:0]  ch_desc_lo,
  output logic [NUM_PAIRS-1:0]      rx_run,
  output logic [NUM_PAIRS*ROW_W-1:0] rx_row_bytes,
  output logic                      addr32_mode,
  output logic                      irq
);
  logic                wr_sts, wr_en_reg, wr_amode;
  logic [NUM_CH-1:0]   sts_q, en_q, pend;
  logic                amode_q, amode_d;
  logic [BUS_DW-1:0]   pair_rd [NUM_PAIRS];
  logic [BUS_DW-1:0]   pair_or, rd_mux, rdata_q, rdata_d;

  assign wr_sts    = bus_wr && (bus_addr == OFS_STATUS);
  assign wr_en_reg = bus_wr && (bus_addr == OFS_ENABLE);
  assign wr_amode  = bus_wr && (bus_addr == OFS_AMODE);

  dmairq_status #(.NUM_CH(NUM_CH)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (wr_sts),
    .clr_mask (bus_wdata[NUM_CH-1:0]),
    .en_we    (wr_en_reg),
    .en_wdata (bus_wdata[NUM_CH-1:0]),
    .done_i   (ch_done),
    .sts_o    (sts_q),
    .en_o     (en_q),
    .pend_o   (pend),
    .irq_o    (irq)
  );

  // channel 2p receives, channel 2p+1 transmits
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic sel;
    assign sel = (bus_addr[BUS_AW-1:WIN_SHIFT] == PAIR_AW'(p));
    dmairq_pair #(.DW(BUS_DW), .ROW_W(ROW_W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .wr_en  (bus_wr),
      .off    (bus_addr[WIN_SHIFT-1:0]),
      .wdata  (bus_wdata),
      .rdata  (pair_rd[p]),
      .rx_dhi (ch_desc_hi[(2*p)*BUS_DW +: BUS_DW]),
      .rx_dlo (ch_desc_lo[(2*p)*BUS_DW +: BUS_DW]),
      .tx_dhi (ch_desc_hi[(2*p+1)*BUS_DW +: BUS_DW]),
      .tx_dlo (ch_desc_lo[(2*p+1)*BUS_DW +: BUS_DW]),
      .rx_run (rx_run[p]),
      .rx_row (rx_row_bytes[p*ROW_W +: ROW_W])
    );
  end

  always_comb begin
    pair_or = '0;
    for (int p = 0; p < NUM_PAIRS; p++) pair_or = pair_or | pair_rd[p];
  end

  always_comb begin
    amode_d = wr_amode ? bus_wdata[0] : amode_q;
    if (bus_addr == OFS_STATUS)      rd_mux = BUS_DW'(sts_q);
    else if (bus_addr == OFS_PEND)   rd_mux = BUS_DW'(pend);
    else if (bus_addr == OFS_ENABLE) rd_mux = BUS_DW'(en_q);
    else if (bus_addr == OFS_AMODE)  rd_mux = BUS_DW'(amode_q);
    else                             rd_mux = pair_or;
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amode_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      amode_q <= amode_d;
      rdata_q <= rdata_d;
    end
  end

  assign addr32_mode = amode_q;
  assign bus_rdata   = rdata_q;
endmodule

// File: rtl/dmairq_regfile_chk.sv
module dmairq_regfile_chk
  import dmairq_pkg::*;
#(
  parameter int unsigned NUM_CH = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] sts_q,
  input logic [NUM_CH-1:0] en_q,
  input logic              irq,
  input logic              addr32_mode
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == OFS_STATUS);

  AST_DONE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_done) |=> ((sts_q & $past(ch_done)) == $past(ch_done))); // R2

  AST_PULSE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(ch_done & bus_wdata[NUM_CH-1:0])) |=>
      ((sts_q & $past(ch_done & bus_wdata[NUM_CH-1:0])) != '0)); // R4

  AST_CLEAR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ch_done == '0) |=>
      (sts_q == ($past(sts_q) & ~$past(bus_wdata[NUM_CH-1:0])))); // R3

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && ch_done == '0) |=> $stable(sts_q)); // R3

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((sts_q & en_q) != '0)); // R6

  AST_AMODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_AMODE) |=> $stable(addr32_mode)); // R8
endmodule

bind dmairq_regfile dmairq_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_dmairq_regfile.sv
module test_dmairq_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 6;
  localparam int RW  = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_wr, bus_rd;
  logic [19:0]      bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic [NCH-1:0]   ch_done;
  logic [NCH*32-1:0] ch_desc_hi, ch_desc_lo;
  logic [NCH/2-1:0] rx_run;
  logic [NCH/2*RW-1:0] rx_row_bytes;
  logic             addr32_mode, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmairq_regfile #(.NUM_CH(NCH), .ROW_W(RW)) i_dmairq_regfile (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_done(ch_done), .ch_desc_hi(ch_desc_hi), .ch_desc_lo(ch_desc_lo),
    .rx_run(rx_run), .rx_row_bytes(rx_row_bytes),
    .addr32_mode(addr32_mode), .irq(irq)
  );

  // op: 0 write, 1 read and compare, 2 completion pulse (mask in data), 3 compare irq
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 20'h80000, 32'h0,        32'h0,        4'd1},  // R1 status zero
    '{2'd1, 20'h80008, 32'h0,        32'h0,        4'd1},  // R1 enable zero
    '{2'd1, 20'h00034, 32'h0,        32'h0,        4'd1},  // R1 amode zero
    '{2'd3, 20'h0,     32'h0,        32'h0,        4'd1},  // R1 irq low
    '{2'd2, 20'h0,     32'h05,       32'h0,        4'd2},  // pulse ch0, ch2
    '{2'd1, 20'h80000, 32'h0,        32'h05,       4'd2},  // R2
    '{2'd3, 20'h0,     32'h0,        32'h0,        4'd6},  // R6 disabled
    '{2'd1, 20'h80004, 32'h0,        32'h0,        4'd5},  // R5
    '{2'd0, 20'h80008, 32'hFFFFFFFF, 32'h0,        4'd7},
    '{2'd1, 20'h80008, 32'h0,        32'h3F,       4'd7},  // R7 upper zero
    '{2'd1, 20'h80004, 32'h0,        32'h05,       4'd5},  // R5
    '{2'd3, 20'h0,     32'h0,        32'h1,        4'd6},  // R6
    '{2'd0, 20'h80004, 32'h0,        32'h0,        4'd5},  // write to pending
    '{2'd1, 20'h80004, 32'h0,        32'h05,       4'd5},  // R5 ignored
    '{2'd0, 20'h80000, 32'h01,       32'h0,        4'd3},
    '{2'd1, 20'h80000, 32'h0,        32'h04,       4'd3},  // R3 only ch0
    '{2'd2, 20'h0,     32'h30,       32'h0,        4'd2},  // pulse ch4, ch5
    '{2'd1, 20'h80000, 32'h0,        32'h34,       4'd2},  // R2
    '{2'd0, 20'h80008, 32'h20,       32'h0,        4'd7},
    '{2'd1, 20'h80004, 32'h0,        32'h20,       4'd5},  // R5 one enabled
    '{2'd0, 20'h80008, 32'hFF,       32'h0,        4'd7},
    '{2'd0, 20'h80000, 32'hFFFFFFFF, 32'h0,        4'd3},
    '{2'd1, 20'h80000, 32'h0,        32'h0,        4'd3},  // R3 all clear
    '{2'd3, 20'h0,     32'h0,        32'h0,        4'd6},  // R6
    '{2'd0, 20'h00034, 32'hFFFFFFFF, 32'h0,        4'd8},
    '{2'd1, 20'h00034, 32'h0,        32'h1,        4'd8},  // R8 bit0 only
    '{2'd0, 20'h00040, 32'h11111111, 32'h0,        4'd9},
    '{2'd0, 20'h00044, 32'hA5A5A5A0, 32'h0,        4'd9},
    '{2'd0, 20'h00058, 32'h22222222, 32'h0,        4'd9},
    '{2'd0, 20'h0005C, 32'h5A5A5A50, 32'h0,        4'd9},
    '{2'd0, 20'h00054, 32'h0000FFFF, 32'h0,        4'd9},
    '{2'd0, 20'h00070, 32'hABCD0280, 32'h0,        4'd9},
    '{2'd1, 20'h00044, 32'h0,        32'hA5A5A5A0, 4'd9},  // R9
    '{2'd1, 20'h00058, 32'h0,        32'h22222222, 4'd9},  // R9
    '{2'd1, 20'h00054, 32'h0,        32'h1,        4'd9},  // R9 run bit
    '{2'd1, 20'h00070, 32'h0,        32'h0280,     4'd9},  // R9 row width
    '{2'd0, 20'h80010, 32'hDEADBEEF, 32'h0,        4'd10},
    '{2'd1, 20'h80010, 32'h0,        32'h0,        4'd10}, // R10 unmapped
    '{2'd1, 20'h00008, 32'h0,        32'h0,        4'd10}, // R10 window gap
    '{2'd1, 20'h000C0, 32'h0,        32'h0,        4'd10}  // R10 no pair 3
  };

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    @(negedge clk);
    ch_done = m;
    @(negedge clk);
    ch_done = '0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; ch_done = '0;
    repeat (3) @(negedge clk);
    check32(bus_rdata, 32'h0, "R1 rdata after reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: bus_write(VECS[i].addr, VECS[i].data);
        2'd1: begin
          bus_read(VECS[i].addr, rd);
          check32(rd, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        end
        2'd2: pulse(VECS[i].data[NCH-1:0]);
        default: begin
          @(negedge clk);
          check32({31'b0, irq}, VECS[i].exp, $sformatf("R%0d vector %0d irq", VECS[i].req, i));
        end
      endcase
    end

    // R9: channel slices follow the pair window (ch2 = RX of pair 1, ch3 = TX)
    check32(ch_desc_hi[2*32 +: 32], 32'h11111111, "R9 ch2 desc hi port");
    check32(ch_desc_lo[2*32 +: 32], 32'hA5A5A5A0, "R9 ch2 desc lo port");
    check32(ch_desc_hi[3*32 +: 32], 32'h22222222, "R9 ch3 desc hi port");
    check32(ch_desc_lo[3*32 +: 32], 32'h5A5A5A50, "R9 ch3 desc lo port");
    check32(32'(rx_run), 32'h2, "R9 run port pair1 only");
    check32(32'(rx_row_bytes[1*RW +: RW]), 32'h0280, "R9 row port");
    check32(ch_desc_lo[0 +: 32], 32'h0, "R10 ch0 untouched by unmapped writes");
    check32({31'b0, addr32_mode}, 32'h1, "R8 addr32_mode port");
    bus_write(20'h00034, 32'h0);
    check32({31'b0, addr32_mode}, 32'h0, "R8 addr32_mode cleared");

    // R4: completion and clear on the same bit in one cycle
    pulse(6'h02);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 20'h80000; bus_wdata = 32'h02; ch_done = 6'h02;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ch_done = '0;
    bus_read(20'h80000, rd);
    check32(rd, 32'h02, "R4 same-bit collision keeps bit");
    check32({31'b0, irq}, 32'h1, "R4 irq stays high");
    // R4: clear bit1 while bit3 completes
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 20'h80000; bus_wdata = 32'h02; ch_done = 6'h08;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ch_done = '0;
    bus_read(20'h80000, rd);
    check32(rd, 32'h08, "R4 mixed clear and set");

    // R1: reset mid-run
    bus_write(20'h00034, 32'h1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check32({30'b0, irq, addr32_mode}, 32'h0, "R1 irq and mode after reset");
    check32(ch_desc_hi[2*32 +: 32], 32'h0, "R1 window cleared");
    rst_n = 1'b1;
    bus_read(20'h80000, rd);
    check32(rd, 32'h0, "R1 status after reset");
    bus_read(20'h80008, rd);
    check32(rd, 32'h0, "R1 enable after reset");

    finished = 1'b1;
    finish_run();
  end
endmodule